// File: doc/BRIEF.md
# Shader Flow-Control Sequencer

This block is the program-counter unit of a small vector shader core. It presents a fetch address on a simple instruction-memory port, receives the instruction word stored there, and decides which address comes next. Alongside the instruction word it receives, from the rest of the core, one boolean uniform bit, a condition flag from the condition evaluator, and a three-field integer uniform. From these it resolves plain and conditional jumps, subroutine calls, two-way if blocks and counted loops. It also keeps an 8-bit loop counter register and a halt flag.

Calls, if blocks and loops all rely on one small return stack. Each entry holds the address at which the scope ends, the address to resume at afterwards, a repeat count, a per-pass increment for the loop counter, and the address where the body begins. An entry whose end address the program counter reaches either sends execution back to the start of the body or is removed. A start pulse loads the entry address and begins execution. An end instruction stops it.

Top module: `shader_flow_seq`

## Requirements
- R1: After reset the fetch address is 0, the halt flag is 1, the overflow flag is 0 and the loop counter is 0.
- R2: In the cycle after a start pulse, the fetch address equals the start offset input, the halt flag and the overflow flag are 0, and the stack is empty. A start pulse has this effect even while the block is halted.
- R3: The instruction word has the opcode in bits [2*AW+3:2*AW], the destination offset in [2*AW-1:AW] and the count in [AW-1:0]. Opcodes: 0 no-op, 1 end, 2 jump on condition, 3 jump on boolean, 4 call, 5 call on boolean, 6 call on condition, 7 if on boolean, 8 if on condition, 9 loop. Opcode 0 and every unlisted opcode only advance the fetch address by 1.
- R4: An end instruction sets the halt flag. While the block is halted, the fetch address and the loop counter hold until the next start pulse.
- R5: A jump whose flag is 1 moves to the destination offset. A jump whose flag is 0 moves to the next address. A jump never pushes a stack entry.
- R6: A call that is taken pushes an entry (start = destination, end = destination + count, return = address + 1, repeat 0, increment 0) and continues at the destination. A call on a flag that is 0 moves to the next address.
- R7: An if instruction whose flag is 1 runs from the next address up to the destination offset, excluding the destination, and then resumes at destination + count.
- R8: An if instruction whose flag is 0 runs count instructions starting at the destination offset, and then resumes at destination + count.
- R9: A loop instruction loads the loop counter from the second integer field. It then runs the body from the next address through the destination offset, inclusive, (first field + 1) times. At the end of each pass it adds the third field to the loop counter. It exits to destination + 1.
- R10: When the stack is not empty and the fetch address equals the top entry's end address, that cycle executes no instruction. The top entry instead either repeats (its count is decremented and execution goes to its start) or pops (execution goes to its return address). The check is made again in the next cycle, so scopes that end at the same address unwind one per cycle.
- R11: The stack holds 4 entries. A push onto a full stack stores nothing and sets the overflow flag, but the fetch address still changes as for a stored push. The overflow flag stays set until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse: load the start offset and run |
| mainOffset | input | AW | Address of the first instruction |
| imemAddr | output | AW | Instruction fetch address (program counter) |
| imemData | input | 2*AW+4 | Instruction word at imemAddr |
| boolUniform | input | 1 | Boolean uniform selected by the current instruction |
| condTrue | input | 1 | Condition evaluator result for the current instruction |
| intX | input | CW | Integer uniform field 1: loop repeat count |
| intY | input | CW | Integer uniform field 2: loop counter start value |
| intZ | input | CW | Integer uniform field 3: loop counter increment per pass |
| loopCnt | output | CW | Loop counter register |
| halted | output | 1 | Execution stopped |
| overflow | output | 1 | Sticky flag: a push was dropped because the stack was full |

## Verification
The hardest state to reach from the ports is a cascade of end-address matches. A loop's last pass ends on the same address at which an enclosing call also ends, so two pops must resolve on consecutive cycles before the instruction at that address may execute. The stimulus builds this with a call whose body is a loop placed exactly at its tail. A second program nests five calls to force a dropped push. The bench's behavioural model tracks every cycle of both programs, including the address that a full-stack call still jumps to.

// File: rtl/fs_pkg.sv
package fs_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_HALT  = 4'd1,
    OP_BRC   = 4'd2,
    OP_BRU   = 4'd3,
    OP_CALL  = 4'd4,
    OP_CALLU = 4'd5,
    OP_CALLC = 4'd6,
    OP_IFU   = 4'd7,
    OP_IFC   = 4'd8,
    OP_LOOP  = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    PS_CALL = 2'd0,
    PS_THEN = 2'd1,
    PS_ELSE = 2'd2,
    PS_LOOP = 2'd3
  } push_sel_e;

  // strobes from control to datapath, at most one PC source active
  typedef struct packed {
    logic      load;
    logic      popRet;
    logic      popLoop;
    logic      push;
    push_sel_e pushSel;
    logic      jump;
    logic      step;
    logic      halt;
    logic      loadLoop;
    logic      ovf;
  } strobe_t;

endpackage

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import fs_pkg::*;
(
  input  logic       start,
  input  logic       halted,
  input  logic       popHit,
  input  logic       topRepZero,
  input  logic       full,
  input  logic [3:0] opField,
  input  logic       boolUniform,
  input  logic       condTrue,
  output strobe_t    strb
);

  op_e op;
  logic wantPush;
  assign op = op_e'(opField);

  always_comb begin
    strb     = '0;
    wantPush = 1'b0;
    if (start) begin
      strb.load = 1'b1;
    end else if (!halted) begin
      if (popHit) begin
        strb.popRet  = topRepZero;
        strb.popLoop = !topRepZero;
      end else begin
        unique case (op)
          OP_HALT: strb.halt = 1'b1;
          OP_BRC: begin strb.jump = condTrue; strb.step = !condTrue; end
          OP_BRU: begin strb.jump = boolUniform; strb.step = !boolUniform; end
          OP_CALL: begin wantPush = 1'b1; strb.pushSel = PS_CALL; strb.jump = 1'b1; end
          OP_CALLU: begin
            wantPush = boolUniform; strb.pushSel = PS_CALL;
            strb.jump = boolUniform; strb.step = !boolUniform;
          end
          OP_CALLC: begin
            wantPush = condTrue; strb.pushSel = PS_CALL;
            strb.jump = condTrue; strb.step = !condTrue;
          end
          OP_IFU: begin
            wantPush = 1'b1; strb.pushSel = boolUniform ? PS_THEN : PS_ELSE;
            strb.step = boolUniform; strb.jump = !boolUniform;
          end
          OP_IFC: begin
            wantPush = 1'b1; strb.pushSel = condTrue ? PS_THEN : PS_ELSE;
            strb.step = condTrue; strb.jump = !condTrue;
          end
          OP_LOOP: begin
            wantPush = 1'b1; strb.pushSel = PS_LOOP;
            strb.loadLoop = 1'b1; strb.step = 1'b1;
          end
          default: strb.step = 1'b1;
        endcase
        strb.push = wantPush && !full;
        strb.ovf  = wantPush && full;
      end
    end
  end

endmodule

// File: rtl/fs_data.sv
module fs_data
  import fs_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [AW-1:0] mainOffset,
  input  logic [AW-1:0] dest,
  input  logic [AW-1:0] count,
  input  logic [CW-1:0] intX,
  input  logic [CW-1:0] intY,
  input  logic [CW-1:0] intZ,
  output logic [AW-1:0] pc,
  output logic [CW-1:0] loopCnt,
  output logic          halted,
  output logic          overflow,
  output logic          popHit,
  output logic          topRepZero,
  output logic          full
);

  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] endA   [DEPTH];
  logic [AW-1:0] retA   [DEPTH];
  logic [AW-1:0] startA [DEPTH];
  logic [CW-1:0] repA   [DEPTH];
  logic [CW-1:0] incA   [DEPTH];
  logic [SPW-1:0] sp;
  logic [IXW-1:0] topIdx;
  logic [AW-1:0] pcNext, nStart, nEnd, nRet;
  logic [CW-1:0] nRep, nInc;

  assign pcNext     = pc + AW'(1);
  assign topIdx     = IXW'(sp - SPW'(1));
  assign full       = (sp == SPW'(DEPTH));
  assign popHit     = (sp != '0) && (pc == endA[topIdx]);
  assign topRepZero = (repA[topIdx] == '0);

  // contents of the entry a push would create
  always_comb begin
    nRep = '0;
    nInc = '0;
    unique case (strb.pushSel)
      PS_CALL: begin nStart = dest;   nEnd = dest + count; nRet = pcNext; end
      PS_THEN: begin nStart = pcNext; nEnd = dest;         nRet = dest + count; end
      PS_ELSE: begin nStart = dest;   nEnd = dest + count; nRet = dest + count; end
      default: begin
        nStart = pcNext; nEnd = dest + AW'(1); nRet = dest + AW'(1);
        nRep = intX; nInc = intZ;
      end
    endcase
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        endA[g] <= '0; retA[g] <= '0; startA[g] <= '0;
        repA[g] <= '0; incA[g] <= '0;
      end else if (strb.push && sp == SPW'(g)) begin
        endA[g] <= nEnd; retA[g] <= nRet; startA[g] <= nStart;
        repA[g] <= nRep; incA[g] <= nInc;
      end else if (strb.popLoop && topIdx == IXW'(g)) begin
        repA[g] <= repA[g] - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp       <= '0;
      pc       <= '0;
      loopCnt  <= '0;
      halted   <= 1'b1;
      overflow <= 1'b0;
    end else begin
      if (strb.load)        sp <= '0;
      else if (strb.push)   sp <= sp + SPW'(1);
      else if (strb.popRet) sp <= sp - SPW'(1);

      if (strb.load)         pc <= mainOffset;
      else if (strb.popRet)  pc <= retA[topIdx];
      else if (strb.popLoop) pc <= startA[topIdx];
      else if (strb.jump)    pc <= dest;
      else if (strb.step)    pc <= pcNext;

      if (strb.popRet || strb.popLoop) loopCnt <= loopCnt + incA[topIdx];
      else if (strb.loadLoop)          loopCnt <= intY;

      if (strb.load)      halted <= 1'b0;
      else if (strb.halt) halted <= 1'b1;

      if (strb.load)     overflow <= 1'b0;
      else if (strb.ovf) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/shader_flow_seq.sv
module shader_flow_seq
  import fs_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CW    = 8,
  parameter int DEPTH = 4,
  localparam int IWD  = 2 * AW + 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [AW-1:0]  mainOffset,
  output logic [AW-1:0]  imemAddr,
  input  logic [IWD-1:0] imemData,
  input  logic           boolUniform,
  input  logic           condTrue,
  input  logic [CW-1:0]  intX,
  input  logic [CW-1:0]  intY,
  input  logic [CW-1:0]  intZ,
  output logic [CW-1:0]  loopCnt,
  output logic           halted,
  output logic           overflow
);

  strobe_t       strb;
  logic [3:0]    opField;
  logic [AW-1:0] destField, cntField;
  logic          popHit, topRepZero, full;

  assign opField   = imemData[IWD-1 -: 4];
  assign destField = imemData[2*AW-1:AW];
  assign cntField  = imemData[AW-1:0];

  fs_ctrl u_ctrl (
    .start       (start),
    .halted      (halted),
    .popHit      (popHit),
    .topRepZero  (topRepZero),
    .full        (full),
    .opField     (opField),
    .boolUniform (boolUniform),
    .condTrue    (condTrue),
    .strb        (strb)
  );

  fs_data #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .mainOffset (mainOffset),
    .dest       (destField),
    .count      (cntField),
    .intX       (intX),
    .intY       (intY),
    .intZ       (intZ),
    .pc         (imemAddr),
    .loopCnt    (loopCnt),
    .halted     (halted),
    .overflow   (overflow),
    .popHit     (popHit),
    .topRepZero (topRepZero),
    .full       (full)
  );

endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic [AW-1:0] mainOffset,
  input logic [AW-1:0] imemAddr,
  input logic [3:0]    opField,
  input logic [AW-1:0] destField,
  input logic          boolUniform,
  input logic [CW-1:0] intY,
  input logic [CW-1:0] loopCnt,
  input logic          halted,
  input logic          overflow,
  input logic          popNow
);

  logic execNow;
  assign execNow = !halted && !start && !popNow;

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (imemAddr == $past(mainOffset)) && !halted && !overflow); // R2

  AST_NOP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    execNow && opField == 4'd0 |=> (imemAddr - $past(imemAddr)) == AW'(1)); // R3

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    halted && !start |=> halted && $stable(imemAddr) && $stable(loopCnt)); // R4

  AST_END_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    execNow && opField == 4'd1 |=> halted); // R4

  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    execNow && opField == 4'd3 && boolUniform |=> imemAddr == $past(destField)); // R5

  AST_LOOP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    execNow && opField == 4'd9 |=> loopCnt == $past(intY)); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !start |=> overflow); // R11

endmodule

bind shader_flow_seq fs_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .mainOffset  (mainOffset),
  .imemAddr    (imemAddr),
  .opField     (opField),
  .destField   (destField),
  .boolUniform (boolUniform),
  .intY        (intY),
  .loopCnt     (loopCnt),
  .halted      (halted),
  .overflow    (overflow),
  .popNow      (strb.popRet | strb.popLoop)
);

// File: tb/sim_shader_flow_seq.sv
module sim_shader_flow_seq;

  localparam int AW = 8;
  localparam int CW = 8;
  localparam int IWD = 2 * AW + 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [AW-1:0]  mainOffset = '0;
  logic [AW-1:0]  imemAddr;
  logic [IWD-1:0] imemData;
  logic           boolUniform, condTrue;
  logic [CW-1:0]  intX, intY, intZ, loopCnt;
  logic           halted, overflow;

  logic [IWD-1:0] prog [256];
  logic           pBool [256];
  logic           pCond [256];
  logic [CW-1:0]  pX [256];
  logic [CW-1:0]  pY [256];
  logic [CW-1:0]  pZ [256];

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit compareOn = 0;

  always #2 clk = ~clk;

  assign imemData    = prog[imemAddr];
  assign boolUniform = pBool[imemAddr];
  assign condTrue    = pCond[imemAddr];
  assign intX        = pX[imemAddr];
  assign intY        = pY[imemAddr];
  assign intZ        = pZ[imemAddr];

  shader_flow_seq u0 (
    .clk(clk), .rstN(rstN), .start(start), .mainOffset(mainOffset),
    .imemAddr(imemAddr), .imemData(imemData), .boolUniform(boolUniform),
    .condTrue(condTrue), .intX(intX), .intY(intY), .intZ(intZ),
    .loopCnt(loopCnt), .halted(halted), .overflow(overflow)
  );

  // ---------------- behavioural reference model ----------------
  int mPc, mLoop;
  bit mHalt, mOvf;
  int qEnd[$], qRet[$], qStart[$], qRep[$], qInc[$];
  string mTag = "R1";

  task automatic mPush(int s, int e, int r, int rp, int inc);
    if (qEnd.size() == 4) begin
      mOvf = 1; mTag = "R11";
    end else begin
      qStart.push_back(s & 255); qEnd.push_back(e & 255); qRet.push_back(r & 255);
      qRep.push_back(rp); qInc.push_back(inc);
    end
  endtask

  task automatic mClear();
    qEnd.delete(); qRet.delete(); qStart.delete(); qRep.delete(); qInc.delete();
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPc = 0; mLoop = 0; mHalt = 1; mOvf = 0; mClear(); mTag = "R1";
    end else if (start) begin
      mPc = int'(mainOffset); mHalt = 0; mOvf = 0; mClear(); mTag = "R2";
    end else if (mHalt) begin
      mTag = "R4";
    end else if (qEnd.size() > 0 && qEnd[$] == mPc) begin
      mTag = "R10";
      mLoop = (mLoop + qInc[$]) & 255;
      if (qRep[$] == 0) begin
        mPc = qRet[$];
        void'(qEnd.pop_back()); void'(qRet.pop_back()); void'(qStart.pop_back());
        void'(qRep.pop_back()); void'(qInc.pop_back());
      end else begin
        qRep[$] = qRep[$] - 1;
        mPc = qStart[$];
      end
    end else begin
      int op, d, n, nxt;
      bit b, c;
      op = int'(prog[mPc][19:16]); d = int'(prog[mPc][15:8]); n = int'(prog[mPc][7:0]);
      b = pBool[mPc]; c = pCond[mPc];
      nxt = (mPc + 1) & 255;
      case (op)
        1: begin mHalt = 1; mTag = "R4"; end
        2: begin mTag = "R5"; mPc = c ? d : nxt; end
        3: begin mTag = "R5"; mPc = b ? d : nxt; end
        4, 5, 6: begin
          mTag = "R6";
          if (op == 4 || (op == 5 && b) || (op == 6 && c)) begin
            mPush(d, d + n, nxt, 0, 0); mPc = d;
          end else mPc = nxt;
        end
        7, 8: begin
          if ((op == 7) ? b : c) begin
            mTag = "R7"; mPush(nxt, d, d + n, 0, 0); mPc = nxt;
          end else begin
            mTag = "R8"; mPush(d, d + n, d + n, 0, 0); mPc = d;
          end
        end
        9: begin
          mTag = "R9"; mLoop = int'(pY[mPc]);
          mPush(nxt, d + 1, d + 1, int'(pX[mPc]), int'(pZ[mPc])); mPc = nxt;
        end
        default: begin mTag = "R3"; mPc = nxt; end
      endcase
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    cycles++;
    if (rstN && compareOn) begin
      checks++;
      if (int'(imemAddr) != mPc || int'(loopCnt) != mLoop || halted != mHalt || overflow != mOvf) begin
        errors++;
        $display("FAIL %s: pc=%0d loop=%0d halt=%0b ovf=%0b expected pc=%0d loop=%0d halt=%0b ovf=%0b",
                 mTag, imemAddr, loopCnt, halted, overflow, mPc, mLoop, mHalt, mOvf);
      end
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic put(int a, int op, int d, int n, bit b = 0, bit c = 0,
                     int x = 0, int y = 0, int z = 0);
    prog[a] = {4'(op), 8'(d), 8'(n)};
    pBool[a] = b; pCond[a] = c;
    pX[a] = 8'(x); pY[a] = 8'(y); pZ[a] = 8'(z);
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runFrom(int off);
    @(negedge clk); start = 1'b1; mainOffset = AW'(off);
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (halted && mHalt) break;
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) put(i, 0, 0, 0);
    // program 1: jumps, if blocks, calls, unlisted opcode
    put(0, 3, 3, 0, 1, 0);       // jump on boolean, taken
    put(1, 1, 0, 0); put(2, 1, 0, 0);
    put(3, 2, 9, 0, 0, 0);       // jump on condition, not taken
    put(4, 8, 7, 2, 0, 1);       // if on condition, true
    put(6, 14, 0, 0);            // unlisted opcode
    put(9, 7, 12, 1, 0, 0);      // if on boolean, false
    put(13, 6, 16, 1, 0, 1);     // call on condition, taken
    put(14, 5, 30, 1, 0, 0);     // call on boolean, not taken
    put(15, 4, 18, 1);           // call
    put(17, 1, 0, 0);            // end
    // program 2: loop x=2 y=5 z=3
    put(20, 9, 22, 0, 0, 0, 2, 5, 3);
    put(23, 1, 0, 0);
    // program 3: five nested calls
    for (int i = 40; i < 45; i++) put(i, 4, i + 1, 51 - (i + 1));
    put(45, 1, 0, 0);
    // program 4: loop ending where the enclosing call ends
    put(60, 4, 62, 3);
    put(61, 1, 0, 0);
    put(62, 9, 64, 0, 0, 0, 1, 0, 1);

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(imemAddr), 0);
    check("R1", int'(halted), 1);
    check("R1", int'(overflow), 0);
    check("R1", int'(loopCnt), 0);
    rstN = 1'b1;
    @(negedge clk);
    compareOn = 1;
    check("R4", int'(imemAddr), 0); // idle until start

    runFrom(0);
    check("R6", int'(imemAddr), 17);
    repeat (5) @(negedge clk);
    check("R4", int'(imemAddr), 17);
    check("R4", int'(halted), 1);

    runFrom(20);
    check("R9", int'(loopCnt), 14);
    check("R9", int'(imemAddr), 23);

    runFrom(40);
    check("R11", int'(overflow), 1);
    check("R11", int'(imemAddr), 45);

    @(negedge clk); start = 1'b1; mainOffset = 8'd60;
    @(negedge clk); start = 1'b0;
    check("R2", int'(overflow), 0);
    check("R2", int'(imemAddr), 60);
    for (int i = 0; i < 400; i++) begin
      if (halted && mHalt) break;
      @(negedge clk);
    end
    check("R10", int'(loopCnt), 2);
    check("R10", int'(imemAddr), 61);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule